// File: doc/BRIEF.md
# EDID Sink Type Detector

This block decides, each time a display is attached, whether the sink must be driven as a plain DVI receiver or may be driven as an HDMI receiver. It follows the hot-plug detect line and reads the sink's EDID one byte at a time through a simple request/valid read port. An external DDC engine serves that port, and checksums are assumed to be checked elsewhere. The sink is treated as DVI from the moment it appears. It is promoted to HDMI only when the EDID has a CEA-type extension block and that block carries a vendor-specific data block with the HDMI identifier and a usable length.

The resulting mode gates the transmitter's feature requests. In DVI mode, requests for video guard bands and for data island periods are suppressed, and the pixel format is forced to RGB. In HDMI mode, the transmitter's requests pass through unchanged. A one-cycle done pulse marks the end of each scan. If the sink is removed during a scan, the scan is abandoned without a done pulse.

Top module: `edid_sink_detect`

## Requirements
- R1: A rising edge on `hpd_i` (after a 2-stage synchronizer) restarts the scan in DVI mode, and the first byte requested is address 126.
- R2: If byte 126 (extension count) reads 0, the scan ends in DVI mode after that single read.
- R3: The byte at address 128 must equal 0x02 for the extension to count as CEA. Any other value ends the scan in DVI mode.
- R4: Byte 130 gives the end offset D of the data block collection. Headers are read at 128+p, starting at p=4, while p<D and p<128. Each header holds tag = bits 7:5 and length L = bits 4:0, and the next header is at p+L+1.
- R5: A header with tag 3 and L>=5, whose next three bytes are 0x03, 0x0C, 0x00, ends the scan in HDMI mode. A tag-3 header with L<5 is skipped like any other block.
- R6: A tag-3 block whose identifier bytes mismatch is skipped, and the walk continues with the following header.
- R7: `pix_fmt_o` is 2'b00 (RGB) in DVI mode. In HDMI mode it equals `pix_fmt_req_i` (00 RGB, 01 YCbCr 4:2:2, 10 YCbCr 4:4:4).
- R8: `gb_en_o` is 0 in DVI mode and equals `gb_req_i` in HDMI mode.
- R9: `di_en_o` is 0 in DVI mode and equals `di_req_i` in HDMI mode.
- R10: `scan_done_o` pulses for exactly one cycle at scan end. `hdmi_mode_o` takes its final value in that same cycle and holds it while `hpd_i` stays high.
- R11: Holding `hpd_i` low aborts any scan with no done pulse. The block then returns to DVI mode and drops `rd_req_o`, within 3 clock cycles.
- R12: `rd_req_o` and `rd_addr_o` hold until `rd_valid_i` is seen with `rd_data_i`. Any read latency gives the same result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| hpd_i | input | 1 | Hot-plug detect level (asynchronous) |
| rd_req_o | output | 1 | EDID byte read request |
| rd_addr_o | output | 8 | EDID byte address |
| rd_data_i | input | 8 | EDID byte returned |
| rd_valid_i | input | 1 | Read data valid strobe |
| pix_fmt_req_i | input | 2 | Requested pixel format |
| gb_req_i | input | 1 | Guard band request |
| di_req_i | input | 1 | Data island request |
| hdmi_mode_o | output | 1 | 1 = HDMI sink, 0 = DVI sink |
| scan_done_o | output | 1 | One-cycle pulse at scan end |
| pix_fmt_o | output | 2 | Pixel format after gating |
| gb_en_o | output | 1 | Guard band enable after gating |
| di_en_o | output | 1 | Data island enable after gating |

## Verification
Random EDID images mix zero and non-zero extension counts, correct and wrong extension tags, and collections of blocks with random tags and lengths. Some of those blocks are identifier-correct or identifier-corrupted vendor blocks. Each image is compared against a walk computed in the bench, under random read latency. Directed images separate the individual exits of the walk: empty extension count, non-CEA tag, a short vendor block, a bad identifier followed by a good one, and a good block sitting after several others. A drop of hot-plug during a scan shows that an abort gives neither a done pulse nor a leftover HDMI mode. Gating checks at random feature requests show that DVI mode masks every request and HDMI mode passes each one unchanged.

// File: rtl/edid_sink_pkg.sv
package edid_sink_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_CNT, ST_TAG, ST_DEND, ST_HDR, ST_ID0, ST_ID1, ST_ID2
  } scan_st_e;

  localparam logic [7:0] CEA_EXT_TAG  = 8'h02;
  localparam logic [2:0] VSDB_TAG     = 3'd3;
  localparam logic [4:0] VSDB_MIN_LEN = 5'd5;
  localparam logic [7:0] HDMI_ID0     = 8'h03;
  localparam logic [7:0] HDMI_ID1     = 8'h0C;
  localparam logic [7:0] HDMI_ID2     = 8'h00;
  localparam logic [7:0] DBC_START    = 8'd4;
  localparam logic [1:0] FMT_RGB      = 2'b00;
endpackage

// File: rtl/edid_hpd_sync.sv
module edid_hpd_sync #(
  parameter int SYNC_N = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hpd_i,
  output logic plug_lvl_o,
  output logic plug_rise_o
);
  logic [SYNC_N-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_N-2:0], hpd_i};
      prev_q <= sync_q[SYNC_N-1];
    end
  end

  assign plug_lvl_o  = sync_q[SYNC_N-1];
  assign plug_rise_o = sync_q[SYNC_N-1] & ~prev_q;
endmodule

// File: rtl/edid_walker.sv
module edid_walker
  import edid_sink_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int CNT_ADDR  = 126,
  parameter int EXT_BASE  = 128,
  parameter int BLK_BYTES = 128
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              plug_lvl_i,
  input  logic              plug_rise_i,
  output logic              rd_req_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic [7:0]        rd_data_i,
  input  logic              rd_valid_i,
  output logic              hdmi_o,
  output logic              done_o
);
  localparam int OFS_W = $clog2(BLK_BYTES);

  scan_st_e  st_q;
  logic [7:0] ptr_q, dend_q;
  logic [4:0] blen_q;
  logic       hdmi_q, done_q;

  logic [8:0] hdr_nxt, blk_nxt;
  logic       hdr_end, blk_end, hdr_vsdb;
  logic [7:0] ofs;

  assign hdr_nxt  = {1'b0, ptr_q} + 9'(rd_data_i[4:0]) + 9'd1;
  assign blk_nxt  = {1'b0, ptr_q} + 9'(blen_q) + 9'd1;
  assign hdr_end  = (hdr_nxt >= {1'b0, dend_q}) || (hdr_nxt >= 9'(BLK_BYTES));
  assign blk_end  = (blk_nxt >= {1'b0, dend_q}) || (blk_nxt >= 9'(BLK_BYTES));
  assign hdr_vsdb = (rd_data_i[7:5] == VSDB_TAG) && (rd_data_i[4:0] >= VSDB_MIN_LEN);

  always_comb begin
    ofs = 8'd0;
    unique case (st_q)
      ST_TAG:  ofs = 8'd0;
      ST_DEND: ofs = 8'd2;
      ST_HDR:  ofs = ptr_q;
      ST_ID0:  ofs = ptr_q + 8'd1;
      ST_ID1:  ofs = ptr_q + 8'd2;
      ST_ID2:  ofs = ptr_q + 8'd3;
      default: ofs = 8'd0;
    endcase
    if (st_q == ST_CNT) rd_addr_o = ADDR_W'(CNT_ADDR);
    else                rd_addr_o = ADDR_W'(EXT_BASE + int'(ofs[OFS_W-1:0]));
  end

  assign rd_req_o = (st_q != ST_IDLE);
  assign hdmi_o   = hdmi_q;
  assign done_o   = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      ptr_q  <= '0;
      dend_q <= '0;
      blen_q <= '0;
      hdmi_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (!plug_lvl_i) begin
        st_q   <= ST_IDLE;
        hdmi_q <= 1'b0;
      end else if (plug_rise_i) begin
        st_q   <= ST_CNT;
        hdmi_q <= 1'b0;
      end else if (rd_valid_i) begin
        unique case (st_q)
          ST_CNT: begin
            if (rd_data_i == 8'd0) begin st_q <= ST_IDLE; done_q <= 1'b1; end
            else st_q <= ST_TAG;
          end
          ST_TAG: begin
            if (rd_data_i == CEA_EXT_TAG) st_q <= ST_DEND;
            else begin st_q <= ST_IDLE; done_q <= 1'b1; end
          end
          ST_DEND: begin
            dend_q <= rd_data_i;
            ptr_q  <= DBC_START;
            if (rd_data_i <= DBC_START) begin st_q <= ST_IDLE; done_q <= 1'b1; end
            else st_q <= ST_HDR;
          end
          ST_HDR: begin
            blen_q <= rd_data_i[4:0];
            if (hdr_vsdb) st_q <= ST_ID0;
            else if (hdr_end) begin st_q <= ST_IDLE; done_q <= 1'b1; end
            else ptr_q <= hdr_nxt[7:0];
          end
          ST_ID0, ST_ID1, ST_ID2: begin
            if ((st_q == ST_ID0 && rd_data_i == HDMI_ID0) ||
                (st_q == ST_ID1 && rd_data_i == HDMI_ID1)) begin
              st_q <= (st_q == ST_ID0) ? ST_ID1 : ST_ID2;
            end else if (st_q == ST_ID2 && rd_data_i == HDMI_ID2) begin
              hdmi_q <= 1'b1;
              done_q <= 1'b1;
              st_q   <= ST_IDLE;
            end else if (blk_end) begin
              st_q   <= ST_IDLE;
              done_q <= 1'b1;
            end else begin
              ptr_q <= blk_nxt[7:0];
              st_q  <= ST_HDR;
            end
          end
          default: st_q <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/edid_mode_gate.sv
module edid_mode_gate
  import edid_sink_pkg::*;
#(
  parameter int FMT_W = 2
) (
  input  logic             hdmi_i,
  input  logic [FMT_W-1:0] pix_fmt_req_i,
  input  logic             gb_req_i,
  input  logic             di_req_i,
  output logic [FMT_W-1:0] pix_fmt_o,
  output logic             gb_en_o,
  output logic             di_en_o
);
  assign pix_fmt_o = hdmi_i ? pix_fmt_req_i : FMT_W'(FMT_RGB);
  assign gb_en_o   = hdmi_i & gb_req_i;
  assign di_en_o   = hdmi_i & di_req_i;
endmodule

// File: rtl/edid_sink_detect.sv
module edid_sink_detect #(
  parameter int ADDR_W = 8,
  parameter int FMT_W  = 2,
  parameter int SYNC_N = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hpd_i,
  output logic              rd_req_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic [7:0]        rd_data_i,
  input  logic              rd_valid_i,
  input  logic [FMT_W-1:0]  pix_fmt_req_i,
  input  logic              gb_req_i,
  input  logic              di_req_i,
  output logic              hdmi_mode_o,
  output logic              scan_done_o,
  output logic [FMT_W-1:0]  pix_fmt_o,
  output logic              gb_en_o,
  output logic              di_en_o
);
  logic plug_lvl, plug_rise;

  edid_hpd_sync #(.SYNC_N(SYNC_N)) u_sync (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .hpd_i       (hpd_i),
    .plug_lvl_o  (plug_lvl),
    .plug_rise_o (plug_rise)
  );

  edid_walker #(.ADDR_W(ADDR_W)) u_walk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .plug_lvl_i  (plug_lvl),
    .plug_rise_i (plug_rise),
    .rd_req_o    (rd_req_o),
    .rd_addr_o   (rd_addr_o),
    .rd_data_i   (rd_data_i),
    .rd_valid_i  (rd_valid_i),
    .hdmi_o      (hdmi_mode_o),
    .done_o      (scan_done_o)
  );

  edid_mode_gate #(.FMT_W(FMT_W)) u_gate (
    .hdmi_i        (hdmi_mode_o),
    .pix_fmt_req_i (pix_fmt_req_i),
    .gb_req_i      (gb_req_i),
    .di_req_i      (di_req_i),
    .pix_fmt_o     (pix_fmt_o),
    .gb_en_o       (gb_en_o),
    .di_en_o       (di_en_o)
  );
endmodule

// File: rtl/edid_sink_detect_chk.sv
module edid_sink_detect_chk #(
  parameter int FMT_W = 2
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             hpd_i,
  input logic             rd_req_o,
  input logic             hdmi_mode_o,
  input logic             scan_done_o,
  input logic [FMT_W-1:0] pix_fmt_req_i,
  input logic [FMT_W-1:0] pix_fmt_o,
  input logic             gb_req_i,
  input logic             di_req_i,
  input logic             gb_en_o,
  input logic             di_en_o
);
  a_r7_rgb_in_dvi: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hdmi_mode_o |-> pix_fmt_o == '0);
  a_r7_fmt_pass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hdmi_mode_o |-> pix_fmt_o == pix_fmt_req_i);
  a_r8_no_guard_dvi: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hdmi_mode_o |-> !gb_en_o);
  a_r8_guard_pass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hdmi_mode_o |-> gb_en_o == gb_req_i);
  a_r9_no_island_dvi: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hdmi_mode_o |-> !di_en_o);
  a_r9_island_pass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hdmi_mode_o |-> di_en_o == di_req_i);
  a_r10_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scan_done_o |=> !scan_done_o);
  a_r10_mode_at_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hdmi_mode_o) |-> scan_done_o);
  a_r10_mode_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_req_o && hpd_i && $past(hpd_i) && $past(!rd_req_o)) |-> $stable(hdmi_mode_o));
  a_r11_unplug_dvi: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hpd_i && $past(!hpd_i) && $past(!hpd_i, 2) && $past(!hpd_i, 3))
      |-> (!hdmi_mode_o && !rd_req_o && !scan_done_o));
endmodule

bind edid_sink_detect edid_sink_detect_chk #(.FMT_W(FMT_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .hpd_i         (hpd_i),
  .rd_req_o      (rd_req_o),
  .hdmi_mode_o   (hdmi_mode_o),
  .scan_done_o   (scan_done_o),
  .pix_fmt_req_i (pix_fmt_req_i),
  .pix_fmt_o     (pix_fmt_o),
  .gb_req_i      (gb_req_i),
  .di_req_i      (di_req_i),
  .gb_en_o       (gb_en_o),
  .di_en_o       (di_en_o)
);

// File: tb/edid_sink_detect_bench.sv
module edid_sink_detect_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       hpd = 1'b0;
  logic       rd_req;
  logic [7:0] rd_addr;
  logic [7:0] rd_data = 8'd0;
  logic       rd_valid = 1'b0;
  logic [1:0] fmt_req = 2'd0;
  logic       gb_req = 1'b0, di_req = 1'b0;
  logic       hdmi, done, gb_en, di_en;
  logic [1:0] fmt;

  int n_tests = 0, n_fail = 0;
  int read_cnt = 0;
  int first_addr = -1;
  int done_cnt = 0;
  logic [7:0] mem [256];

  always #2 clk = ~clk;

  edid_sink_detect u_edid_sink_detect (
    .clk_i(clk), .rst_ni(rst_n), .hpd_i(hpd),
    .rd_req_o(rd_req), .rd_addr_o(rd_addr), .rd_data_i(rd_data), .rd_valid_i(rd_valid),
    .pix_fmt_req_i(fmt_req), .gb_req_i(gb_req), .di_req_i(di_req),
    .hdmi_mode_o(hdmi), .scan_done_o(done), .pix_fmt_o(fmt),
    .gb_en_o(gb_en), .di_en_o(di_en)
  );

  task automatic check(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // responder with random latency
  initial begin
    forever begin
      @(negedge clk);
      if (rd_req && hpd) begin
        repeat ($urandom % 4) @(negedge clk);
        if (rd_req) begin
          if (read_cnt == 0) first_addr = int'(rd_addr);
          read_cnt++;
          rd_data  = mem[rd_addr];
          rd_valid = 1'b1;
          @(negedge clk);
          rd_valid = 1'b0;
        end
      end
    end
  end

  always @(negedge clk) if (done) done_cnt++;

  function automatic bit ref_hdmi();
    int p, e;
    if (mem[126] == 8'd0) return 1'b0;
    if (mem[128] != 8'h02) return 1'b0;
    e = int'(mem[130]);
    p = 4;
    while (p < e && p < 128) begin
      if (mem[128+p][7:5] == 3'd3 && mem[128+p][4:0] >= 5'd5 &&
          mem[128+p+1] == 8'h03 && mem[128+p+2] == 8'h0C && mem[128+p+3] == 8'h00)
        return 1'b1;
      p = p + int'(mem[128+p][4:0]) + 1;
    end
    return 1'b0;
  endfunction

  task automatic clear_edid();
    for (int i = 0; i < 256; i++) mem[i] = 8'd0;
    mem[126] = 8'd1;
    mem[128] = 8'h02;
  endtask

  // place block at offset p, returns next offset
  task automatic put_blk(inout int p, input int tag, input int len, input bit good_id);
    mem[128+p] = {3'(tag), 5'(len)};
    for (int k = 1; k <= len; k++) mem[128+p+k] = 8'(k + 8'h40);
    if (tag == 3 && len >= 3) begin
      mem[128+p+1] = 8'h03;
      mem[128+p+2] = good_id ? 8'h0C : 8'h0D;
      mem[128+p+3] = 8'h00;
    end
    p = p + len + 1;
  endtask

  task automatic build_rand();
    int p;
    for (int i = 0; i < 256; i++) mem[i] = 8'($urandom);
    mem[126] = ($urandom % 6 == 0) ? 8'd0 : 8'd1;
    mem[128] = ($urandom % 8 == 0) ? 8'h70 : 8'h02;
    p = 4;
    for (int k = 0; k < int'($urandom % 6); k++) begin
      if ($urandom % 3 == 0) put_blk(p, 3, 3 + int'($urandom % 6), ($urandom % 3) != 0);
      else put_blk(p, int'($urandom % 8), int'($urandom % 9), 1'b1);
    end
    mem[130] = 8'(p);
  endtask

  task automatic replug();
    hpd = 1'b0;
    repeat (6) @(negedge clk);
    read_cnt = 0;
    first_addr = -1;
    done_cnt = 0;
    hpd = 1'b1;
  endtask

  task automatic run_scan(input string tag, input bit exp);
    int to;
    bit got;
    got = 1'b0;
    replug();
    to = 0;
    while (!got && to < 3000) begin
      @(negedge clk);
      if (done) got = 1'b1;
      to++;
    end
    check({tag, " R10 done seen"}, int'(got), 1);
    check({tag, " R5 mode"}, int'(hdmi), int'(exp));
    @(negedge clk);
    check({tag, " R10 done one cycle"}, int'(done), 0);
    repeat (3) @(negedge clk);
    check({tag, " R10 mode held"}, int'(hdmi), int'(exp));
    check({tag, " R1 first addr 126"}, first_addr, 126);
  endtask

  task automatic gate_check(input bit exp);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      fmt_req = 2'($urandom % 3);
      gb_req  = 1'($urandom);
      di_req  = 1'($urandom);
      #1;
      check("R7 pix fmt", int'(fmt), exp ? int'(fmt_req) : 0);
      check("R8 guard band", int'(gb_en), exp ? int'(gb_req) : 0);
      check("R9 data island", int'(di_en), exp ? int'(di_req) : 0);
    end
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int p;
    void'($urandom(32'h5EED_1234));
    clear_edid();
    repeat (3) @(negedge clk);
    check("R1 reset mode", int'(hdmi), 0);
    check("R12 reset req", int'(rd_req), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R10 reset done", int'(done), 0);

    // R2: zero extension count, one read only
    clear_edid();
    mem[126] = 8'd0;
    run_scan("R2 no ext", 1'b0);
    check("R2 single read", read_cnt, 1);
    gate_check(1'b0);

    // R3: non-CEA tag
    clear_edid();
    mem[128] = 8'h10;
    p = 4; put_blk(p, 3, 6, 1'b1); mem[130] = 8'(p);
    run_scan("R3 bad tag", 1'b0);

    // R5: short vendor block
    clear_edid();
    p = 4; put_blk(p, 3, 4, 1'b1); mem[130] = 8'(p);
    run_scan("R5 short vsdb", 1'b0);

    // R6: bad id then good id
    clear_edid();
    p = 4; put_blk(p, 3, 7, 1'b0); put_blk(p, 3, 5, 1'b1); mem[130] = 8'(p);
    run_scan("R6 bad then good", 1'b1);
    gate_check(1'b1);

    // R4: good block after other blocks
    clear_edid();
    p = 4; put_blk(p, 2, 9, 1'b1); put_blk(p, 1, 3, 1'b1); put_blk(p, 4, 0, 1'b1);
    put_blk(p, 3, 8, 1'b1); mem[130] = 8'(p);
    run_scan("R4 walk", 1'b1);

    // R4: good block beyond collection end is not reached
    clear_edid();
    p = 4; put_blk(p, 2, 5, 1'b1); mem[130] = 8'(p); put_blk(p, 3, 6, 1'b1);
    run_scan("R4 past end", 1'b0);

    // R11: abort mid-scan
    clear_edid();
    p = 4; put_blk(p, 2, 4, 1'b1); put_blk(p, 3, 6, 1'b1); mem[130] = 8'(p);
    replug();
    while (read_cnt < 3) @(negedge clk);
    hpd = 1'b0;
    repeat (5) @(negedge clk);
    check("R11 abort mode", int'(hdmi), 0);
    check("R11 abort req", int'(rd_req), 0);
    check("R11 abort no done", done_cnt, 0);
    gate_check(1'b0);
    run_scan("R11 rescan", 1'b1);

    // R1: replug after HDMI sink with DVI image
    clear_edid();
    mem[128] = 8'h03;
    run_scan("R1 replug", 1'b0);

    // random images under random read latency (R12)
    for (int t = 0; t < 40; t++) begin
      bit e;
      build_rand();
      e = ref_hdmi();
      run_scan("R12 random", e);
      gate_check(e);
    end

    finish_run();
  end
endmodule